// File: doc/BRIEF.md
# Processor Halt and Restart Sequencer

This block lets host-side logic stop an embedded processor and, if asked, restart it from a new address, without software stepping through the register accesses. It works through three registers of the processor's control block: a state register, a mode register that holds a halt bit, and a program-counter register. It reaches them over a simple request/acknowledge register bus. A command carries a halt-only or halt-then-start choice and a 32-bit start address.

The halt phase repeats a fixed attempt until the halt bit reads back set. Each attempt clears all state bits, writes the halt bit, then reads the mode register back. A pause separates the attempts, and the number of attempts has a limit. A start command then goes on to load the program counter and verifies it by reading it back. On a mismatch it halts again, pauses for a longer time and rewrites the counter, with its own limit on attempts. When the value matches, it clears state and writes zero to the mode register, which lets the processor run. Both pauses are counted in clock cycles, computed from a clock-frequency parameter and a duration in microseconds. The sequencer ends each command with either a done pulse or an error pulse.

Top module: `proc_restart_seq`

## Requirements
- R1: After reset, busy, done, err and busReq are all low.
- R2: A halt attempt makes exactly three accesses in this order: a write of 0xFFFFFFFF to the state register, a write of (1 << HALT_BIT) to the mode register, and a read of the mode register.
- R3: A halt-only command whose mode read-back has bit HALT_BIT set ends with a done pulse and no further access.
- R4: When the read-back halt bit is clear and attempts remain, busReq stays low for exactly CLK_HZ/1e6*HALT_US cycles, and then the next halt attempt begins.
- R5: When the halt bit is still clear on attempt HALT_TRIES, the sequencer pulses err and returns to idle without touching the PC register or writing zero to the mode register.
- R6: After a successful halt, a start command writes 0xFFFFFFFF to the state register, writes the command address to the PC register, and reads the PC register back.
- R7: On a PC read-back mismatch with attempts left, it writes 0xFFFFFFFF to the state register and (1 << HALT_BIT) to the mode register. It then holds busReq low for exactly CLK_HZ/1e6*PC_US cycles and rewrites the PC register. The state is not cleared again before that rewrite.
- R8: On a PC match, it writes 0xFFFFFFFF to the state register, then 0x00000000 to the mode register, and then pulses done.
- R9: A PC mismatch on attempt PC_TRIES pulses err and ends the command with no further access.
- R10: busy is high from the cycle after a command is accepted until the cycle in which done or err is high. In that cycle busy is low. A cmdValid seen while busy changes neither the access sequence nor the address used.
- R11: busReq, busWe, busAddr and busWdata stay stable until busAck. busRdata is used only in the busAck cycle.
- R12: done and err are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, taken only when idle |
| cmdStart | input | 1 | 1: halt then load address and start; 0: halt only |
| cmdAddr | input | 32 | Start address for the processor |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse: command completed |
| err | output | 1 | One-cycle pulse: retry limit reached |
| busReq | output | 1 | Register access request |
| busWe | output | 1 | 1 write, 0 read |
| busAddr | output | ADDR_W | Register offset |
| busWdata | output | 32 | Write data |
| busAck | input | 1 | Access complete; read data valid in this cycle |
| busRdata | input | 32 | Read data |

## Verification
A wrong FSM state would show up at the ports as a bus access out of order or a wrong register offset, at the very next request. A wrong retry counter would show up only after the whole retry loop. It appears as one attempt too many or too few before err, or as a missing err pulse, so the limits are tested with exactly HALT_TRIES and PC_TRIES failing read-backs. A fault in the delay timer shows up as a gap of the wrong length before the following access. The bus model returns wrong read data outside the acknowledge cycle, so data sampled early turns at once into a wrong branch.

// File: rtl/proc_seq_pkg.sv
package proc_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WR_STATE,
    OP_WR_HALT,
    OP_RD_MODE,
    OP_WR_PC,
    OP_RD_PC,
    OP_WR_RUN
  } busOp_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_HCLR,
    S_HMODE,
    S_HREAD,
    S_HWAIT,
    S_PCLR,
    S_PWR,
    S_PREAD,
    S_PCLR2,
    S_PHALT,
    S_PWAIT,
    S_RCLR,
    S_RMODE
  } seqState_e;

  typedef struct packed {
    busOp_e op;
    logic   latchCmd;
    logic   clrHalt;
    logic   incHalt;
    logic   clrPc;
    logic   incPc;
    logic   ldHaltDly;
    logic   ldPcDly;
  } ctrlStrobes_t;

endpackage

// File: rtl/proc_seq_ctrl.sv
module proc_seq_ctrl
  import proc_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic         cmdStart,
  input  logic         busAck,
  input  logic         haltSeen,
  input  logic         haltLast,
  input  logic         pcMatch,
  input  logic         pcLast,
  input  logic         dlyZero,
  output ctrlStrobes_t stb,
  output logic         busy,
  output logic         done,
  output logic         err
);

  seqState_e state, stateNxt;
  logic      startReq;
  logic      finDone, finErr;

  always_comb begin
    stb      = '0;
    stb.op   = OP_NONE;
    stateNxt = state;
    finDone  = 1'b0;
    finErr   = 1'b0;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        stb.latchCmd = 1'b1;
        stb.clrHalt  = 1'b1;
        stb.clrPc    = 1'b1;
        stateNxt     = S_HCLR;
      end
      S_HCLR: begin
        stb.op = OP_WR_STATE;
        if (busAck) stateNxt = S_HMODE;
      end
      S_HMODE: begin
        stb.op = OP_WR_HALT;
        if (busAck) stateNxt = S_HREAD;
      end
      S_HREAD: begin
        stb.op = OP_RD_MODE;
        if (busAck) begin
          if (haltSeen) begin
            stateNxt = startReq ? S_PCLR : S_IDLE;
            finDone  = !startReq;
          end else if (haltLast) begin
            stateNxt = S_IDLE;
            finErr   = 1'b1;
          end else begin
            stb.ldHaltDly = 1'b1;
            stateNxt      = S_HWAIT;
          end
        end
      end
      S_HWAIT: if (dlyZero) begin
        stb.incHalt = 1'b1;
        stateNxt    = S_HCLR;
      end
      S_PCLR: begin
        stb.op = OP_WR_STATE;
        if (busAck) stateNxt = S_PWR;
      end
      S_PWR: begin
        stb.op = OP_WR_PC;
        if (busAck) stateNxt = S_PREAD;
      end
      S_PREAD: begin
        stb.op = OP_RD_PC;
        if (busAck) begin
          if (pcMatch) stateNxt = S_RCLR;
          else if (pcLast) begin
            stateNxt = S_IDLE;
            finErr   = 1'b1;
          end else stateNxt = S_PCLR2;
        end
      end
      S_PCLR2: begin
        stb.op = OP_WR_STATE;
        if (busAck) stateNxt = S_PHALT;
      end
      S_PHALT: begin
        stb.op = OP_WR_HALT;
        if (busAck) begin
          stb.ldPcDly = 1'b1;
          stateNxt    = S_PWAIT;
        end
      end
      S_PWAIT: if (dlyZero) begin
        stb.incPc = 1'b1;
        stateNxt  = S_PWR;
      end
      S_RCLR: begin
        stb.op = OP_WR_STATE;
        if (busAck) stateNxt = S_RMODE;
      end
      S_RMODE: begin
        stb.op = OP_WR_RUN;
        if (busAck) begin
          stateNxt = S_IDLE;
          finDone  = 1'b1;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      startReq <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= finDone;
      err   <= finErr;
      if (stb.latchCmd) startReq <= cmdStart;
    end
  end

  assign busy = (state != S_IDLE);

  p_busy_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid) |=> busy);
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    (done || err) |=> !(done || err));
  p_done_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));
  p_finish_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done || err) |-> !busy);

endmodule

// File: rtl/proc_seq_dp.sv
module proc_seq_dp
  import proc_seq_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          HALT_BIT   = 10,
  parameter int          HALT_TRIES = 10000,
  parameter int          PC_TRIES   = 8,
  parameter int          HALT_DLY   = 2500,
  parameter int          PC_DLY     = 250000,
  parameter logic [ADDR_W-1:0] MODE_OFS  = 'h00,
  parameter logic [ADDR_W-1:0] STATE_OFS = 'h04,
  parameter logic [ADDR_W-1:0] PC_OFS    = 'h1C
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      stb,
  input  logic [31:0]       cmdAddr,
  input  logic              busAck,
  input  logic [31:0]       busRdata,
  output logic              haltSeen,
  output logic              haltLast,
  output logic              pcMatch,
  output logic              pcLast,
  output logic              dlyZero,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata
);

  localparam int HCW    = $clog2(HALT_TRIES + 1);
  localparam int PCW    = $clog2(PC_TRIES + 1);
  localparam int DLYMAX = (HALT_DLY > PC_DLY) ? HALT_DLY : PC_DLY;
  localparam int DW     = $clog2(DLYMAX + 1);
  localparam logic [31:0] HALT_MASK = 32'(1) << HALT_BIT;

  logic [31:0]  addrReg;
  logic [HCW-1:0] haltCnt;
  logic [PCW-1:0] pcCnt;
  logic [DW-1:0]  dlyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      haltCnt <= '0;
      pcCnt   <= '0;
      dlyCnt  <= '0;
    end else begin
      if (stb.latchCmd) addrReg <= cmdAddr;
      if (stb.clrHalt)      haltCnt <= '0;
      else if (stb.incHalt) haltCnt <= haltCnt + 1'b1;
      if (stb.clrPc)        pcCnt <= '0;
      else if (stb.incPc)   pcCnt <= pcCnt + 1'b1;
      if (stb.ldHaltDly)    dlyCnt <= DW'(HALT_DLY - 1);
      else if (stb.ldPcDly) dlyCnt <= DW'(PC_DLY - 1);
      else if (dlyCnt != '0) dlyCnt <= dlyCnt - 1'b1;
    end
  end

  assign haltSeen = busRdata[HALT_BIT];
  assign pcMatch  = (busRdata == addrReg);
  assign haltLast = (haltCnt == HCW'(HALT_TRIES - 1));
  assign pcLast   = (pcCnt == PCW'(PC_TRIES - 1));
  assign dlyZero  = (dlyCnt == '0);

  always_comb begin
    busReq   = 1'b1;
    busWe    = 1'b1;
    busAddr  = STATE_OFS;
    busWdata = '0;
    unique case (stb.op)
      OP_WR_STATE: busWdata = '1;
      OP_WR_HALT: begin busAddr = MODE_OFS; busWdata = HALT_MASK; end
      OP_RD_MODE: begin busAddr = MODE_OFS; busWe = 1'b0; end
      OP_WR_PC:   begin busAddr = PC_OFS; busWdata = addrReg; end
      OP_RD_PC:   begin busAddr = PC_OFS; busWe = 1'b0; end
      OP_WR_RUN:  busAddr = MODE_OFS;
      default: begin busReq = 1'b0; busWe = 1'b0; end
    endcase
  end

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busWe) && $stable(busAddr) && $stable(busWdata)));
  p_wait_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dlyCnt != '0) |-> !busReq);
  p_halt_cnt_r5: assert property (@(posedge clk) disable iff (!rstN)
    haltCnt < HCW'(HALT_TRIES));
  p_pc_cnt_r9: assert property (@(posedge clk) disable iff (!rstN)
    pcCnt < PCW'(PC_TRIES));

endmodule

// File: rtl/proc_restart_seq.sv
module proc_restart_seq
  import proc_seq_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          HALT_BIT   = 10,
  parameter int          CLK_HZ     = 250_000_000,
  parameter int          HALT_US    = 10,
  parameter int          PC_US      = 1000,
  parameter int          HALT_TRIES = 10000,
  parameter int          PC_TRIES   = 8,
  parameter logic [ADDR_W-1:0] MODE_OFS  = 'h00,
  parameter logic [ADDR_W-1:0] STATE_OFS = 'h04,
  parameter logic [ADDR_W-1:0] PC_OFS    = 'h1C
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdStart,
  input  logic [31:0]       cmdAddr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  input  logic              busAck,
  input  logic [31:0]       busRdata
);

  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int HALT_RAW   = CYC_PER_US * HALT_US;
  localparam int PC_RAW     = CYC_PER_US * PC_US;
  localparam int HALT_DLY   = (HALT_RAW < 1) ? 1 : HALT_RAW;
  localparam int PC_DLY     = (PC_RAW < 1) ? 1 : PC_RAW;

  ctrlStrobes_t stb;
  logic haltSeen, haltLast, pcMatch, pcLast, dlyZero;

  proc_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdStart(cmdStart),
    .busAck(busAck), .haltSeen(haltSeen), .haltLast(haltLast),
    .pcMatch(pcMatch), .pcLast(pcLast), .dlyZero(dlyZero),
    .stb(stb), .busy(busy), .done(done), .err(err)
  );

  proc_seq_dp #(
    .ADDR_W(ADDR_W), .HALT_BIT(HALT_BIT), .HALT_TRIES(HALT_TRIES),
    .PC_TRIES(PC_TRIES), .HALT_DLY(HALT_DLY), .PC_DLY(PC_DLY),
    .MODE_OFS(MODE_OFS), .STATE_OFS(STATE_OFS), .PC_OFS(PC_OFS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdAddr(cmdAddr),
    .busAck(busAck), .busRdata(busRdata),
    .haltSeen(haltSeen), .haltLast(haltLast), .pcMatch(pcMatch),
    .pcLast(pcLast), .dlyZero(dlyZero),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata)
  );

endmodule

// File: tb/sim_proc_restart_seq.sv
module sim_proc_restart_seq;

  localparam int HT = 4;
  localparam int PT = 3;
  localparam int HD = 10;
  localparam int PD = 50;
  localparam int HBIT = 10;
  localparam logic [31:0] MASK = 32'(1) << HBIT;
  localparam logic [15:0] A_MODE = 16'h00, A_STATE = 16'h04, A_PC = 16'h1C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdStart = 1'b0;
  logic [31:0] cmdAddr = '0;
  logic busy, done, err, busReq, busWe;
  logic [15:0] busAddr;
  logic [31:0] busWdata;
  logic busAck = 1'b0;
  logic [31:0] busRdata = '1;

  always #2 clk = ~clk;

  proc_restart_seq #(
    .ADDR_W(16), .HALT_BIT(HBIT), .CLK_HZ(1_000_000), .HALT_US(HD), .PC_US(PD),
    .HALT_TRIES(HT), .PC_TRIES(PT)
  ) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdStart(cmdStart), .cmdAddr(cmdAddr),
    .busy(busy), .done(done), .err(err), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata)
  );

  typedef struct {
    logic        we;
    logic [15:0] addr;
    logic [31:0] data;
    int          gap;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0, fails = 0;
  int haltFails = 0, pcBad = 0, ackLat = 0;
  logic [31:0] modeReg = '0, pcReg = '0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic we, input logic [15:0] addr, input logic [31:0] data,
                      input int gap, input string tag);
    expItem_t it;
    it.we = we; it.addr = addr; it.data = data; it.gap = gap; it.tag = tag;
    expQ.push_back(it);
  endtask

  // bus slave and monitor: pops expected accesses and compares them
  initial begin
    int gap = 0, curGap = 0, wcnt = 0;
    bit started = 0;
    forever begin
      @(negedge clk);
      if (busy && !busReq) gap++;
      if (busAck) begin
        busAck = 1'b0;
        busRdata = '1;
      end else if (busReq) begin
        if (!started) begin
          started = 1; curGap = gap; gap = 0; wcnt = 0;
        end
        if (wcnt == ackLat) begin
          started = 0;
          if (expQ.size() == 0) begin
            check(0, "R10", "unexpected access addr", 32'(busAddr), 32'hFFFF);
          end else begin
            expItem_t e;
            e = expQ.pop_front();
            check(busWe == e.we && busAddr == e.addr, e.tag, "access kind/addr",
                  {15'd0, busWe, busAddr}, {15'd0, e.we, e.addr});
            if (e.we) check(busWdata == e.data, e.tag, "write data", busWdata, e.data);
            check(curGap == e.gap, e.tag, "idle gap", 32'(curGap), 32'(e.gap));
          end
          if (busWe) begin
            if (busAddr == A_MODE) modeReg = busWdata;
            else if (busAddr == A_PC) begin
              if (pcBad > 0) begin pcReg = busWdata ^ 32'h4; pcBad--; end
              else pcReg = busWdata;
            end
          end else begin
            if (busAddr == A_MODE) begin
              if (haltFails > 0) begin busRdata = modeReg & ~MASK; haltFails--; end
              else busRdata = modeReg;
            end else busRdata = pcReg;
          end
          busAck = 1'b1;
        end else wcnt++;
      end
    end
  end

  task automatic runCmd(input bit isStart, input logic [31:0] addr, input int hFail,
                        input int pFail, input int lat, input bit inject);
    bit haltOk = 0, pcOk = 0, expDone;
    int k;
    for (int i = 0; i < HT; i++) begin
      push(1, A_STATE, '1, (i == 0) ? 0 : HD, (i == 0) ? "R2" : "R4");
      push(1, A_MODE, MASK, 0, "R2");
      push(0, A_MODE, '0, 0, "R2");
      if (i >= hFail) begin haltOk = 1; break; end
    end
    if (haltOk && isStart) begin
      push(1, A_STATE, '1, 0, "R6");
      for (int j = 0; j < PT; j++) begin
        push(1, A_PC, addr, (j == 0) ? 0 : PD, (j == 0) ? "R6" : "R7");
        push(0, A_PC, '0, 0, "R6");
        if (j >= pFail) begin pcOk = 1; break; end
        if (j == PT - 1) break;
        push(1, A_STATE, '1, 0, "R7");
        push(1, A_MODE, MASK, 0, "R7");
      end
      if (pcOk) begin
        push(1, A_STATE, '1, 0, "R8");
        push(1, A_MODE, '0, 0, "R8");
      end
    end
    expDone = haltOk && (!isStart || pcOk);
    haltFails = hFail; pcBad = pFail; ackLat = lat;

    @(negedge clk);
    cmdValid = 1'b1; cmdStart = isStart; cmdAddr = addr;
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy == 1'b1, "R10", "busy after accept", 32'(busy), 1);
    k = 0;
    while (!(done || err) && k < 5000) begin
      if (!busy) check(0, "R10", "busy dropped early", 0, 1);
      if (inject && k == 5) begin
        cmdValid = 1'b1; cmdStart = 1'b0; cmdAddr = 32'h1234_5678;
      end
      if (inject && k == 6) cmdValid = 1'b0;
      @(negedge clk);
      k++;
    end
    check(done == expDone, expDone ? "R3" : "R5", "done at finish", 32'(done), 32'(expDone));
    check(err == !expDone, isStart ? "R9" : "R5", "err at finish", 32'(err), 32'(!expDone));
    check(busy == 1'b0, "R10", "busy in finish cycle", 32'(busy), 0);
    @(negedge clk);
    check(!done && !err, "R12", "pulse length", {30'd0, done, err}, 0);
    check(expQ.size() == 0, "R11", "accesses left unseen", 32'(expQ.size()), 0);
    expQ.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !busReq, "R1", "outputs in reset",
          {28'd0, busy, done, err, busReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err && !busReq, "R1", "outputs after reset",
          {28'd0, busy, done, err, busReq}, 0);
    runCmd(0, 32'h0, 0, 0, 0, 0);            // R3 halt on first try
    runCmd(0, 32'h0, 2, 0, 2, 0);            // R4 two retries
    runCmd(0, 32'h0, HT, 0, 1, 0);           // R5 halt limit
    runCmd(1, 32'h0000_4000, 0, 0, 1, 0);    // R6 R8 clean start
    runCmd(1, 32'h0800_0ABC, 1, 2, 0, 1);    // R7 R10 retries and ignored command
    runCmd(1, 32'h00C0_FFEE, 0, PT, 2, 0);   // R9 PC limit
    runCmd(1, 32'h0000_0100, HT + 1, 0, 0, 0); // R5 no start after halt failure
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule